// File: doc/BRIEF.md
# Receiver Gain Loop Controller

This block closes a digital gain loop around an external variable-gain amplifier. It takes one stream of signed 14-bit ADC samples and estimates the signal power from them. From that estimate it chooses a 3-bit gain code that keeps the level at the ADC input close to a programmed target. The power estimate is the square of each sample, passed through a first-order leaky average. The level derived from it is compared against a target window, and the window has a deadband and hysteresis.

While the level stays outside the window, an integrator counts the samples. After a programmable number of them it moves the gain code by one step, down when the signal is too strong and up when it is too weak. The code saturates at both ends. A one-cycle strobe marks each change of the code so that downstream logic can compensate for it. Four write-only configuration registers hold the target, the deadband, the hysteresis and the two time-constant shifts.

Top module: `agc_ctrl`

## Requirements
- R1: During and after reset, gain_o is 7 (the maximum code), gain_chg_o is 0, and the power estimate and the integrator count are zero.
- R2: On every accepted sample s, the power estimate P becomes P + ((s*s - P) >>> D), where >>> is an arithmetic shift and D is the detector shift. The level used for decisions is P >> 11, taken from the estimate before the update.
- R3: A write with cfg_we_i high stores cfg_wdata_i into a register selected by cfg_addr_i: 0 is the target T, 1 is the deadband B, 2 is the hysteresis H, and 3 holds the shifts, with D in bits [3:0] and the loop shift L in bits [7:4]. The new value is used from the next sample on.
- R4: From the in-window state, a level above T+B+H enters the too-high state and a level below T-B-H enters the too-low state. These comparisons are signed, so the lower bound may be negative.
- R5: The too-high state is left only when the level is at most T+B, and the too-low state only when the level is at least T-B. A level between T+B and T+B+H, or between T-B-H and T-B, therefore keeps the current state.
- R6: The integrator counts samples spent in the same out-of-window state. The gain moves on the 2^L-th such sample, and the count then restarts. The count also restarts on entering a state or changing direction, and it is zero while the level is in the window.
- R7: A gain step is a decrement in the too-high state and an increment in the too-low state.
- R8: gain_o changes by at most one per sample and saturates at 0 and 7 without wrapping.
- R9: gain_chg_o is 1 exactly in the cycle after a clock edge at which gain_o changed, and 0 otherwise.
- R10: Cycles with smp_valid_i low change neither gain_o nor any loop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_i | input | 14 | Signed ADC sample |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | 16 | Register write data |
| gain_o | output | 3 | Gain code for the amplifier |
| gain_chg_o | output | 1 | One-cycle strobe after a gain change |

## Verification
Several properties are checked on every cycle:
- the gain code moves by at most one step per update;
- a decrement happens only in the too-high state and an increment only in the too-low state;
- the strobe matches every change of the code;
- the power estimate stays bounded;
- the zone state and the gain hold through cycles without samples;
- the integrator count is zero while the level is in the window.

Other behaviours need the bench's scenarios, which compare every output against an independent model:
- the exact averaging arithmetic;
- the placement of the threshold and deadband edges;
- the hysteresis band;
- the sample count before a step;
- the effect of each configuration register.

// File: rtl/agc_pkg.sv
`timescale 1ns/1ps
package agc_pkg;
  localparam int CFG_W = 16;

  typedef enum logic [1:0] {
    ZN_IDLE = 2'd0,
    ZN_HIGH = 2'd1,
    ZN_LOW  = 2'd2
  } zone_e;

  typedef struct packed {
    logic [CFG_W-1:0] thr;
    logic [CFG_W-1:0] dband;
    logic [CFG_W-1:0] hyst;
    logic [3:0]       det_sh;
    logic [3:0]       loop_sh;
  } agc_cfg_t;
endpackage

// File: rtl/agc_cfg_regs.sv
`timescale 1ns/1ps
module agc_cfg_regs
  import agc_pkg::*;
#(
  parameter logic [CFG_W-1:0] THR_RST = 16'h1000,
  parameter logic [CFG_W-1:0] DB_RST  = 16'h0100,
  parameter logic [CFG_W-1:0] HY_RST  = 16'h0080,
  parameter logic [3:0]       DSH_RST = 4'd0,
  parameter logic [3:0]       LSH_RST = 4'd2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output agc_cfg_t         cfg_o
);
  agc_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.thr     <= THR_RST;
      cfg_q.dband   <= DB_RST;
      cfg_q.hyst    <= HY_RST;
      cfg_q.det_sh  <= DSH_RST;
      cfg_q.loop_sh <= LSH_RST;
    end else if (we_i) begin
      unique case (addr_i)
        2'd0: cfg_q.thr   <= wdata_i;
        2'd1: cfg_q.dband <= wdata_i;
        2'd2: cfg_q.hyst  <= wdata_i;
        default: begin
          cfg_q.det_sh  <= wdata_i[3:0];
          cfg_q.loop_sh <= wdata_i[7:4];
        end
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/agc_pwr_det.sv
`timescale 1ns/1ps
module agc_pwr_det #(
  parameter int SW = 14,
  parameter int LW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [SW-1:0] smp_i,
  input  logic [3:0]           shift_i,
  output logic [LW-1:0]        level_o
);
  localparam int PW     = 2*SW - 1;   // holds (-2^(SW-1))^2
  localparam int LVL_SH = PW - LW;

  logic signed [2*SW-1:0] sq_s;
  logic [PW-1:0]          sq, pwr_q, pwr_d;
  logic signed [PW:0]     diff, step;

  assign sq_s  = smp_i * smp_i;
  assign sq    = sq_s[PW-1:0];
  assign diff  = $signed({1'b0, sq}) - $signed({1'b0, pwr_q});
  assign step  = diff >>> shift_i;
  assign pwr_d = pwr_q + step[PW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pwr_q <= '0;
    else if (valid_i) pwr_q <= pwr_d;
  end

  assign level_o = pwr_q[PW-1:LVL_SH];

  p_pwr_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_q <= (PW'(1) << (PW-1)));
  p_pwr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pwr_q));
endmodule

// File: rtl/agc_zone.sv
`timescale 1ns/1ps
module agc_zone
  import agc_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] thr_i,
  input  logic [LW-1:0] dband_i,
  input  logic [LW-1:0] hyst_i,
  output zone_e         zone_q_o,
  output zone_e         zone_d_o
);
  localparam int CW = LW + 3;

  logic signed [CW-1:0] lvl_s, thr_s, db_s, hy_s;
  logic signed [CW-1:0] hi_in, hi_out, lo_in, lo_out;
  zone_e zone_q, zone_d;

  assign lvl_s  = $signed({3'b000, level_i});
  assign thr_s  = $signed({3'b000, thr_i});
  assign db_s   = $signed({3'b000, dband_i});
  assign hy_s   = $signed({3'b000, hyst_i});
  assign hi_out = thr_s + db_s;
  assign hi_in  = hi_out + hy_s;
  assign lo_out = thr_s - db_s;
  assign lo_in  = lo_out - hy_s;

  always_comb begin
    zone_d = zone_q;
    if (valid_i) begin
      unique case (zone_q)
        ZN_IDLE: if (lvl_s > hi_in)        zone_d = ZN_HIGH;
                 else if (lvl_s < lo_in)   zone_d = ZN_LOW;
        ZN_HIGH: if (lvl_s <= hi_out)      zone_d = ZN_IDLE;
        ZN_LOW:  if (lvl_s >= lo_out)      zone_d = ZN_IDLE;
        default:                           zone_d = ZN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zone_q <= ZN_IDLE;
    else         zone_q <= zone_d;
  end

  assign zone_q_o = zone_q;
  assign zone_d_o = zone_d;

  p_zone_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(zone_q));
  p_high_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && zone_q == ZN_HIGH && lvl_s > hi_out) |=> zone_q == ZN_HIGH);
  p_low_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && zone_q == ZN_LOW && lvl_s < lo_out) |=> zone_q == ZN_LOW);
endmodule

// File: rtl/agc_loop_int.sv
`timescale 1ns/1ps
module agc_loop_int
  import agc_pkg::*;
#(
  parameter int GW = 3,
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  zone_e         zone_q_i,
  input  zone_e         zone_d_i,
  input  logic [3:0]    loop_sh_i,
  output logic [GW-1:0] gain_o,
  output logic          chg_o
);
  logic [AW-1:0] acc_q, acc_d, base, lim_m1;
  logic [GW-1:0] gain_q, gain_d;
  logic          chg_q;

  assign lim_m1 = (AW'(1) << loop_sh_i) - AW'(1);
  assign base   = (zone_d_i != zone_q_i) ? '0 : acc_q;

  always_comb begin
    acc_d  = acc_q;
    gain_d = gain_q;
    if (valid_i) begin
      if (zone_d_i == ZN_IDLE) begin
        acc_d = '0;
      end else if (base >= lim_m1) begin
        acc_d = '0;
        if (zone_d_i == ZN_HIGH && gain_q != '0) gain_d = gain_q - 1'b1;
        if (zone_d_i == ZN_LOW  && gain_q != '1) gain_d = gain_q + 1'b1;
      end else begin
        acc_d = base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      gain_q <= '1;
      chg_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      gain_q <= gain_d;
      chg_q  <= (gain_d != gain_q);
    end
  end

  assign gain_o = gain_q;
  assign chg_o  = chg_q;

  p_one_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_q != $past(gain_q)) |->
      (gain_q == $past(gain_q) + 1'b1 || gain_q + 1'b1 == $past(gain_q)));
  p_down_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_q < $past(gain_q)) |-> zone_q_i == ZN_HIGH);
  p_up_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_q > $past(gain_q)) |-> zone_q_i == ZN_LOW);
  p_idle_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zone_q_i == ZN_IDLE) |-> acc_q == '0);
endmodule

// File: rtl/agc_ctrl.sv
`timescale 1ns/1ps
module agc_ctrl
  import agc_pkg::*;
#(
  parameter int SW = 14,
  parameter int GW = 3,
  parameter int AW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_valid_i,
  input  logic signed [SW-1:0] smp_i,
  input  logic                 cfg_we_i,
  input  logic [1:0]           cfg_addr_i,
  input  logic [CFG_W-1:0]     cfg_wdata_i,
  output logic [GW-1:0]        gain_o,
  output logic                 gain_chg_o
);
  agc_cfg_t         cfg;
  logic [CFG_W-1:0] level;
  zone_e            zone_q, zone_d;

  agc_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg)
  );

  agc_pwr_det #(.SW(SW), .LW(CFG_W)) u_det (
    .clk_i, .rst_ni,
    .valid_i(smp_valid_i), .smp_i(smp_i), .shift_i(cfg.det_sh),
    .level_o(level)
  );

  agc_zone #(.LW(CFG_W)) u_zone (
    .clk_i, .rst_ni,
    .valid_i(smp_valid_i), .level_i(level),
    .thr_i(cfg.thr), .dband_i(cfg.dband), .hyst_i(cfg.hyst),
    .zone_q_o(zone_q), .zone_d_o(zone_d)
  );

  agc_loop_int #(.GW(GW), .AW(AW)) u_loop (
    .clk_i, .rst_ni,
    .valid_i(smp_valid_i), .zone_q_i(zone_q), .zone_d_i(zone_d),
    .loop_sh_i(cfg.loop_sh),
    .gain_o(gain_o), .chg_o(gain_chg_o)
  );

  p_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_chg_o == (gain_o != $past(gain_o)));
  p_gain_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(gain_o));
endmodule

// File: tb/agc_ctrl_tb.sv
`timescale 1ns/1ps
module agc_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic signed [13:0] smp_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [2:0]  gain_o;
  logic        gain_chg_o;

  agc_ctrl u_dut (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {int gain; bit chg; string tag;} exp_t;
  exp_t sb_q[$];

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // model state
  longint m_pwr = 0;
  int m_zone = 0, m_acc = 0, m_gain = 7;
  int c_thr = 4096, c_db = 256, c_hy = 128, c_dsh = 0, c_lsh = 2;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    cfg_addr_i = addr[1:0]; cfg_wdata_i = data[15:0]; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    case (addr)
      0: c_thr = data;
      1: c_db = data;
      2: c_hy = data;
      default: begin c_dsh = data & 15; c_lsh = (data >> 4) & 15; end
    endcase
  endtask

  // driver: computes expected result from the requirements and queues it
  task automatic send(int s, string tag);
    longint lvl, sq, d;
    int nz, base, lim, og;
    exp_t e;
    sq  = longint'(s) * longint'(s);
    lvl = m_pwr >> 11;
    nz = m_zone;
    if (m_zone == 0) begin
      if (lvl > c_thr + c_db + c_hy) nz = 1;
      else if (lvl < c_thr - c_db - c_hy) nz = 2;
    end else if (m_zone == 1) begin
      if (lvl <= c_thr + c_db) nz = 0;
    end else begin
      if (lvl >= c_thr - c_db) nz = 0;
    end
    base = (nz != m_zone) ? 0 : m_acc;
    lim = (1 << c_lsh) - 1;
    og = m_gain;
    if (nz == 0) m_acc = 0;
    else if (base >= lim) begin
      m_acc = 0;
      if (nz == 1 && m_gain > 0) m_gain--;
      if (nz == 2 && m_gain < 7) m_gain++;
    end else m_acc = base + 1;
    m_zone = nz;
    d = sq - m_pwr;
    m_pwr = m_pwr + (d >>> c_dsh);
    e.gain = m_gain; e.chg = (m_gain != og); e.tag = tag;
    sb_q.push_back(e);
    smp_i = s[13:0]; smp_valid_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic burst(int amp, int n, string tag);
    for (int i = 0; i < n; i++) send((i % 2) ? -amp : amp, tag);
    smp_valid_i = 1'b0;
  endtask

  task automatic gap(int n);
    smp_valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: pops and compares after every edge
  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (smp_valid_i) begin
        exp_t e;
        #2;
        if (sb_q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R9 actual=output expected=empty scoreboard");
        end else begin
          e = sb_q.pop_front();
          check({e.tag, " gain"}, int'(gain_o), e.gain);
          check("R9 strobe", int'(gain_chg_o), int'(e.chg));
        end
      end else begin
        #2;
        check("R10 idle gain", int'(gain_o), m_gain);
        check("R10 idle strobe", int'(gain_chg_o), 0);
      end
    end
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset gain", int'(gain_o), 7);
    check("R1 reset strobe", int'(gain_chg_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", int'(gain_o), 7);
    // R3: program all registers explicitly
    wr(0, 4096); wr(1, 256); wr(2, 128); wr(3, 8'h20);
    // R8 upper saturation: too weak while at max
    burst(1000, 12, "R8 sat high");
    gap(2);
    // R6/R7/R8: too strong, step every 4 samples down to 0
    burst(4000, 36, "R7 down");
    gap(3);
    // back into window: no change, count cleared (R6)
    burst(2896, 10, "R6 window");
    // R7 up, weak signal ramps the gain back
    burst(1000, 32, "R7 up");
    // R4: level 4394 lies between T+B and T+B+H: no entry from window
    burst(2896, 4, "R4 settle");
    burst(3000, 10, "R4 no entry");
    // R5: enter high then hold inside hysteresis band
    burst(4000, 1, "R5 enter");
    burst(3000, 12, "R5 hold high");
    burst(2780, 4, "R5 exit");
    // R5 low side: enter then hold between T-B-H and T-B
    burst(1000, 1, "R5 enter low");
    burst(2780, 12, "R5 hold low");
    // R10 with sparse samples
    for (int i = 0; i < 8; i++) begin send(4000, "R10 sparse"); gap(3); end
    // R6: L=0 steps every sample; direction changes restart count
    wr(3, 8'h00);
    burst(1000, 6, "R6 L0 up");
    burst(4000, 6, "R6 L0 down");
    wr(3, 8'h30);
    burst(1000, 11, "R6 L3 up");
    burst(4000, 5, "R6 dir change");
    // R2: detector smoothing D=3, step response
    wr(3, 8'h13);
    burst(0, 20, "R2 decay");
    burst(4000, 40, "R2 rise");
    burst(500, 40, "R2 fall");
    // R3/R4: retarget low, zero deadband, signed lower bound
    wr(0, 400); wr(1, 0); wr(2, 0); wr(3, 8'h10);
    burst(1000, 20, "R3 new target");
    wr(0, 10); wr(1, 300); wr(2, 300);
    burst(0, 30, "R4 negative bound");
    gap(4);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule